// File: doc/BRIEF.md
# Region Access Guard

This block checks every memory access a processor makes against a small table of programmable regions. The processor has no address translation. Each region is a naturally aligned block of physical memory whose size is a power of two. It carries access rights, a no-execute flag, a supervisor-only flag and a two-bit cache hint. An access presents an address, a kind (load, store or instruction fetch) and the privilege of the requester. In the same cycle the block answers with allow or fault, and a faulting access must not complete. The cache hint of the winning region is passed through untouched.

Supervisor code rewrites the table through a simple write port, typically at every task switch, so that each task runs against its own set of regions. The write port refuses writes from user mode. A refused write is reported as a fault.

A sticky status record keeps the first fault: its address and its kind. It holds until software clears it.

Top module: `rgn_guard`

## Requirements
- R1: The table holds NUM_REGIONS regions (at most 16), each with its own base, size exponent and attribute byte. A supervisor write (`cfg_we`=1, `cfg_priv`=1) to index `cfg_idx` takes effect from the next clock edge. Reset leaves every region disabled.
- R2: The size exponent is clamped to the range 5..ADDR_W, so the smallest region is 32 bytes. The stored base is forced down to a multiple of the region size. An address hits an enabled region when it lies in [base, base + 2^size).
- R3: The attribute layout is: bit 6 enable, bits 5:4 cache hint, bit 3 supervisor-only, bit 2 no-execute, bits 1:0 permission. The permission codes are 0 no access, 1 read-only, 2 read-write and 3 reserved (no access). Access kinds are 0 load, 1 store and 2 fetch. Read-only allows loads and fetches. Read-write allows all three kinds.
- R4: A fetch from a region with the no-execute bit set faults, whatever its permission.
- R5: A user-mode access (`acc_priv`=0) to a supervisor-only region faults.
- R6: When several enabled regions hit, the highest-numbered one alone decides the outcome and the cache hint.
- R7: An address that hits no enabled region is allowed in supervisor mode and faults in user mode. Its cache hint is 0.
- R8: For a valid access, exactly one of `acc_allow` and `acc_fault` is high, combinationally in the same cycle. `acc_cache` shows the deciding region's hint.
- R9: A table write from user mode changes no region and raises `cfg_fault` in that cycle.
- R10: On the edge after a fault, while no fault is held, the status record captures the fault. An access fault records the address and the access kind. A refused table write records `cfg_base` and kind 3. An access fault wins when both occur in the same cycle. The record then holds until `flt_clr` removes it, and later faults do not overwrite it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Region table write strobe |
| cfg_priv | input | 1 | Writer is in supervisor mode |
| cfg_idx | input | $clog2(NUM_REGIONS) | Region index to write |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size | input | $clog2(ADDR_W+1) | Region size exponent |
| cfg_attr | input | 7 | Region attribute byte (layout in R3) |
| cfg_fault | output | 1 | User-mode table write refused |
| acc_valid | input | 1 | Access present |
| acc_addr | input | ADDR_W | Access address |
| acc_type | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| acc_priv | input | 1 | Access is in supervisor mode |
| acc_allow | output | 1 | Access may complete |
| acc_fault | output | 1 | Access is blocked |
| acc_cache | output | 2 | Cache hint of the deciding region |
| flt_clr | input | 1 | Clear the fault record |
| flt_valid | output | 1 | A fault is held |
| flt_addr | output | ADDR_W | Held fault address |
| flt_type | output | 2 | Held fault kind (3 = refused table write) |

## Verification
A corrupted base, size or attribute word shows in the same cycle: accesses near that region's edges get the wrong allow/fault answer or the wrong cache hint. A full address sweep after each table load therefore finds it at once. A priority error shows only where regions overlap, and the sweeps cover those overlaps. An error in the fault record shows one edge after the first fault, as a wrong address or kind, or as a record that changes while it should hold.

// File: rtl/rgn_guard_pkg.sv
package rgn_guard_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_CFG   = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        PERM_NONE = 2'd0,
        PERM_RO   = 2'd1,
        PERM_RW   = 2'd2,
        PERM_RSVD = 2'd3
    } perm_e;

    localparam int MIN_SIZE_EXP = 5;

    typedef struct packed {
        logic       en;
        logic [1:0] cache;
        logic       sup_only;
        logic       no_exec;
        perm_e      perm;
    } rgn_attr_t;

    function automatic logic rights_ok(rgn_attr_t a, acc_kind_e k, logic sup);
        logic ok;
        unique case (a.perm)
            PERM_RO: ok = (k == KIND_LOAD) || (k == KIND_FETCH);
            PERM_RW: ok = (k == KIND_LOAD) || (k == KIND_STORE) || (k == KIND_FETCH);
            default: ok = 1'b0;
        endcase
        if (k == KIND_FETCH && a.no_exec) ok = 1'b0;
        if (a.sup_only && !sup)           ok = 1'b0;
        return ok;
    endfunction

endpackage

// File: rtl/rgn_store.sv
module rgn_store
    import rgn_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    localparam int IDXW       = $clog2(NUM_REGIONS),
    localparam int SZW        = $clog2(ADDR_W + 1)
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                cfg_we,
    input  logic                                cfg_priv,
    input  logic [IDXW-1:0]                     cfg_idx,
    input  logic [ADDR_W-1:0]                   cfg_base,
    input  logic [SZW-1:0]                      cfg_size,
    input  rgn_attr_t                           cfg_attr,
    output logic                                cfg_fault,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_q,
    output logic [NUM_REGIONS-1:0][SZW-1:0]     size_q,
    output rgn_attr_t [NUM_REGIONS-1:0]         attr_q
);

    logic [SZW-1:0]    size_fix;
    logic [ADDR_W-1:0] base_fix;
    logic              wr_ok;

    always_comb begin
        if (cfg_size < SZW'(MIN_SIZE_EXP))  size_fix = SZW'(MIN_SIZE_EXP);
        else if (cfg_size > SZW'(ADDR_W))   size_fix = SZW'(ADDR_W);
        else                                size_fix = cfg_size;
        base_fix = cfg_base & ({ADDR_W{1'b1}} << size_fix);
    end

    assign wr_ok     = cfg_we && cfg_priv;
    assign cfg_fault = cfg_we && !cfg_priv;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                base_q[i] <= '0;
                size_q[i] <= SZW'(MIN_SIZE_EXP);
                attr_q[i] <= '0;
            end
        end else if (wr_ok) begin
            base_q[cfg_idx] <= base_fix;
            size_q[cfg_idx] <= size_fix;
            attr_q[cfg_idx] <= cfg_attr;
        end
    end

    // R9
    user_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_priv) |=> (attr_q == $past(attr_q)) && (base_q == $past(base_q)));

    // R2
    base_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> ((base_q[$past(cfg_idx)] & ~({ADDR_W{1'b1}} << size_q[$past(cfg_idx)])) == '0));

endmodule

// File: rtl/rgn_match.sv
module rgn_match
    import rgn_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    localparam int SZW        = $clog2(ADDR_W + 1)
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0]  base_q,
    input  logic [NUM_REGIONS-1:0][SZW-1:0]     size_q,
    input  rgn_attr_t [NUM_REGIONS-1:0]         attr_q,
    output logic [NUM_REGIONS-1:0]              hit
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
        logic [ADDR_W-1:0] keep;
        assign keep   = {ADDR_W{1'b1}} << size_q[g];
        assign hit[g] = attr_q[g].en && (((addr ^ base_q[g]) & keep) == '0);
    end

endmodule

// File: rtl/rgn_decide.sv
module rgn_decide
    import rgn_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        acc_valid,
    input  acc_kind_e                   acc_kind,
    input  logic                        acc_priv,
    input  logic [NUM_REGIONS-1:0]      hit,
    input  rgn_attr_t [NUM_REGIONS-1:0] attr_q,
    output logic                        found,
    output rgn_attr_t                   win_attr,
    output logic                        acc_allow,
    output logic                        acc_fault,
    output logic [1:0]                  acc_cache
);

    logic ok;

    always_comb begin
        found    = 1'b0;
        win_attr = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hit[i]) begin
                found    = 1'b1;
                win_attr = attr_q[i];
            end
        end
        ok        = found ? rights_ok(win_attr, acc_kind, acc_priv) : acc_priv;
        acc_allow = acc_valid && ok;
        acc_fault = acc_valid && !ok;
        acc_cache = found ? win_attr.cache : 2'b00;
    end

    // R7
    default_user_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (hit == '0) && !acc_priv) |-> acc_fault);

    // R8
    one_answer_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> $onehot({acc_allow, acc_fault}));

endmodule

// File: rtl/rgn_fault_log.sv
module rgn_fault_log
    import rgn_guard_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_fault,
    input  logic [ADDR_W-1:0] acc_addr,
    input  acc_kind_e         acc_kind,
    input  logic              cfg_fault,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              flt_clr,
    output logic              flt_valid,
    output logic [ADDR_W-1:0] flt_addr,
    output logic [1:0]        flt_type
);

    logic free;
    assign free = !flt_valid || flt_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_valid <= 1'b0;
            flt_addr  <= '0;
            flt_type  <= 2'b00;
        end else if (free && acc_fault) begin
            flt_valid <= 1'b1;
            flt_addr  <= acc_addr;
            flt_type  <= acc_kind;
        end else if (free && cfg_fault) begin
            flt_valid <= 1'b1;
            flt_addr  <= cfg_base;
            flt_type  <= KIND_CFG;
        end else if (flt_clr) begin
            flt_valid <= 1'b0;
        end
    end

    // R10
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_fault && !flt_valid) |=> flt_valid && (flt_addr == $past(acc_addr)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !flt_clr) |=> flt_valid && $stable(flt_addr) && $stable(flt_type));

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
    import rgn_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cfg_we,
    input  logic                           cfg_priv,
    input  logic [$clog2(NUM_REGIONS)-1:0] cfg_idx,
    input  logic [ADDR_W-1:0]              cfg_base,
    input  logic [$clog2(ADDR_W+1)-1:0]    cfg_size,
    input  logic [6:0]                     cfg_attr,
    output logic                           cfg_fault,
    input  logic                           acc_valid,
    input  logic [ADDR_W-1:0]              acc_addr,
    input  logic [1:0]                     acc_type,
    input  logic                           acc_priv,
    output logic                           acc_allow,
    output logic                           acc_fault,
    output logic [1:0]                     acc_cache,
    input  logic                           flt_clr,
    output logic                           flt_valid,
    output logic [ADDR_W-1:0]              flt_addr,
    output logic [1:0]                     flt_type
);

    localparam int SZW = $clog2(ADDR_W + 1);

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_q;
    logic [NUM_REGIONS-1:0][SZW-1:0]    size_q;
    rgn_attr_t [NUM_REGIONS-1:0]        attr_q;
    logic [NUM_REGIONS-1:0]             hit;
    logic                               found;
    rgn_attr_t                          win_attr;
    acc_kind_e                          kind;

    assign kind = acc_kind_e'(acc_type);

    rgn_store #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_attr(rgn_attr_t'(cfg_attr)), .cfg_fault(cfg_fault),
        .base_q(base_q), .size_q(size_q), .attr_q(attr_q)
    );

    rgn_match #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_match (
        .addr(acc_addr), .base_q(base_q), .size_q(size_q),
        .attr_q(attr_q), .hit(hit)
    );

    rgn_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_kind(kind),
        .acc_priv(acc_priv), .hit(hit), .attr_q(attr_q), .found(found),
        .win_attr(win_attr), .acc_allow(acc_allow), .acc_fault(acc_fault),
        .acc_cache(acc_cache)
    );

    rgn_fault_log #(.ADDR_W(ADDR_W)) u_log (
        .clk(clk), .rst(rst), .acc_fault(acc_fault), .acc_addr(acc_addr),
        .acc_kind(kind), .cfg_fault(cfg_fault), .cfg_base(cfg_base),
        .flt_clr(flt_clr), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_type(flt_type)
    );

    // R4
    no_exec_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && kind == KIND_FETCH && found && win_attr.no_exec) |-> acc_fault);

    // R5
    sup_only_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_priv && found && win_attr.sup_only) |-> !acc_allow);

endmodule

// File: tb/rgn_guard_bench.sv
module rgn_guard_bench;

    localparam int N   = 4;
    localparam int AW  = 12;
    localparam int SZW = $clog2(AW + 1);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_we = 1'b0, cfg_priv = 1'b0;
    logic [1:0]     cfg_idx = '0;
    logic [AW-1:0]  cfg_base = '0;
    logic [SZW-1:0] cfg_size = '0;
    logic [6:0]     cfg_attr = '0;
    logic           cfg_fault;
    logic           acc_valid = 1'b0, acc_priv = 1'b0;
    logic [AW-1:0]  acc_addr = '0;
    logic [1:0]     acc_type = '0;
    logic           acc_allow, acc_fault;
    logic [1:0]     acc_cache;
    logic           flt_clr = 1'b0;
    logic           flt_valid;
    logic [AW-1:0]  flt_addr;
    logic [1:0]     flt_type;

    int checks = 0;
    int errors = 0;

    int sh_base [N];
    int sh_size [N];
    int sh_attr [N];

    always #4 clk = ~clk;

    rgn_guard #(.NUM_REGIONS(N), .ADDR_W(AW)) u_rgn_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_attr(cfg_attr), .cfg_fault(cfg_fault), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_type(acc_type), .acc_priv(acc_priv),
        .acc_allow(acc_allow), .acc_fault(acc_fault), .acc_cache(acc_cache),
        .flt_clr(flt_clr), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_type(flt_type)
    );

    function automatic int mk(int en, int cache, int sup, int nx, int perm);
        return (en << 6) | (cache << 4) | (sup << 3) | (nx << 2) | perm;
    endfunction

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // R1 R2 R9: shadow updated only for supervisor writes, with clamp and alignment
    task automatic wr(int idx, int base, int size, int attr, int sup);
        int s;
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = sup[0]; cfg_idx = idx[1:0];
        cfg_base = base[AW-1:0]; cfg_size = size[SZW-1:0]; cfg_attr = attr[6:0];
        if (sup != 0) begin
            s = (size < 5) ? 5 : ((size > AW) ? AW : size);
            sh_size[idx] = s;
            sh_base[idx] = (base >> s) << s;
            sh_attr[idx] = attr;
        end
        @(negedge clk);
        cfg_we = 1'b0; cfg_priv = 1'b0;
    endtask

    // returns {allow, cache}
    function automatic int model(int a, int k, int sup);
        int w = -1;
        int at, p, ok;
        for (int i = 0; i < N; i++)
            if (((sh_attr[i] >> 6) & 1) == 1 && a >= sh_base[i] && a < sh_base[i] + (1 << sh_size[i]))
                w = i;
        if (w < 0) return (sup << 2);
        at = sh_attr[w];
        p  = at & 3;
        ok = (p == 1) ? (k != 1) : ((p == 2) ? 1 : 0);
        if (k == 2 && ((at >> 2) & 1) == 1) ok = 0;
        if (((at >> 3) & 1) == 1 && sup == 0) ok = 0;
        return (ok << 2) | ((at >> 4) & 3);
    endfunction

    task automatic sweep(string tag);
        int e, got;
        for (int a = 0; a < (1 << AW); a += 8) begin
            for (int k = 0; k < 3; k++) begin
                for (int s = 0; s < 2; s++) begin
                    @(negedge clk);
                    acc_valid = 1'b1; acc_addr = a[AW-1:0]; acc_type = k[1:0]; acc_priv = s[0];
                    #1;
                    e   = model(a, k, s);
                    got = {acc_allow, acc_cache};
                    // R3 R4 R5 R6 R7: allow and cache hint against the model
                    check({tag, " R3/R4/R5/R6/R7"}, got, e);
                    // R8: exactly one answer
                    check({tag, " R8"}, {acc_allow, acc_fault}, (e >> 2) != 0 ? 2 : 1);
                end
            end
        end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            sh_base[i] = 0; sh_size[i] = 5; sh_attr[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state, everything disabled, no fault held
        acc_valid = 1'b1; acc_addr = 12'h010; acc_type = 2'd0; acc_priv = 1'b0;
        #1;
        check("R1 reset user default", acc_fault, 1);
        acc_priv = 1'b1;
        #1;
        check("R1 reset sup default", acc_allow, 1);
        check("R10 reset record", flt_valid, 0);
        acc_valid = 1'b0;

        // Table A: nested and overlapping regions
        wr(0, 12'h000, 10, mk(1, 1, 1, 0, 2), 1);
        wr(1, 12'h100, 8,  mk(1, 2, 0, 0, 1), 1);
        wr(2, 12'h180, 6,  mk(1, 3, 0, 1, 2), 1);
        wr(3, 12'h800, 9,  mk(1, 0, 0, 0, 2), 1);
        sweep("tableA");

        // Table B (task switch): clamp, reserved perm, none perm, disabled slot
        wr(0, 12'h7E9, 2,  mk(1, 1, 0, 0, 1), 1);
        wr(1, 12'hC00, 8,  mk(1, 2, 0, 0, 3), 1);
        wr(2, 12'h000, 11, mk(1, 3, 1, 1, 2), 1);
        wr(3, 12'h200, 7,  mk(1, 0, 0, 0, 0), 1);
        sweep("tableB");
        wr(1, 12'hC00, 8,  mk(0, 2, 0, 0, 2), 1);
        wr(3, 12'h400, 15, mk(1, 2, 0, 0, 1), 1);
        sweep("tableB2");

        // R10: fault record capture, hold, clear
        @(negedge clk); flt_clr = 1'b1;
        @(negedge clk); flt_clr = 1'b0;
        check("R10 cleared", flt_valid, 0);
        acc_valid = 1'b1; acc_addr = 12'hC04; acc_type = 2'd1; acc_priv = 1'b0;
        @(negedge clk);
        acc_addr = 12'h100; acc_type = 2'd2;
        check("R10 capture valid", flt_valid, 1);
        check("R10 capture addr", flt_addr, 12'hC04);
        check("R10 capture kind", flt_type, 1);
        @(negedge clk);
        acc_valid = 1'b0;
        check("R10 hold addr", flt_addr, 12'hC04);
        check("R10 hold kind", flt_type, 1);
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0;
        check("R10 clear", flt_valid, 0);

        // R9: user-mode table write refused, flagged and recorded
        @(negedge clk);
        cfg_we = 1'b1; cfg_priv = 1'b0; cfg_idx = 2'd2;
        cfg_base = 12'h5A0; cfg_size = 4'd5; cfg_attr = 7'(mk(1, 0, 0, 0, 2));
        #1;
        check("R9 cfg_fault", cfg_fault, 1);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R9 cfg_fault drops", cfg_fault, 0);
        check("R10 cfg record valid", flt_valid, 1);
        check("R10 cfg record addr", flt_addr, 12'h5A0);
        check("R10 cfg record kind", flt_type, 3);
        sweep("after user write R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule